// File: doc/BRIEF.md
# Guest/Host World Switch Sequencer

This block runs the hardware side of a context switch between a host monitor and one guest. An entry command carries the word address of the guest's control block. The sequencer first stores the host's state registers into a host save area, whose base comes from a separate configuration input. It then reads the guest's intercept vector and control word from the control block. Next it loads the guest's register state from the block, and finally it raises the guest-mode flag. While the guest runs, any event whose intercept bit is set starts an exit. On exit the sequencer writes the guest registers back, stores the exit cause, and reloads the host registers from the save area.

All transfers use one simple memory port with a request/acknowledge handshake, carrying one 64-bit word per beat. The state being switched is reached through a register-file port. The sequencer names a register by index. It reads that register combinationally when saving and writes it with a strobe when loading. A separate global interrupt flag is set and cleared by its own commands.

Control block layout, in words from its base: offset 0 is the intercept vector, offset 1 is the control word, offset 2 receives the exit code, and offsets 3 to 3+NREG-1 hold guest register 0 to NREG-1. The host save area holds host register i at base+i.

Top module: `wsw_seq`

## Requirements
- R1: After reset, busy, guest_mode, nested_en, gif, mem_req and exit_code are all 0.
- R2: An entry command (cmd_op = 1) accepted in idle first writes host registers 0..7, read through rf_sel/rf_rdata, to hsave_base+0..7 in that order. These are the first memory beats.
- R3: After the host save, entry reads cmd_blk_base+0 (intercept vector) and then cmd_blk_base+1 (control word). It then reads cmd_blk_base+3+i and writes each word into register i, for i = 0..7 in order. guest_mode rises when the last load completes.
- R4: At the end of entry, nested_en takes bit 0 of the control word. Every exit clears nested_en.
- R5: In guest mode, an exit starts on the first cycle in which evt_vec AND intercept vector is nonzero. exit_code is the lowest index set in that AND. It is also written zero-extended to cmd_blk_base+2.
- R6: An exit writes registers 0..7 to cmd_blk_base+3..10, then writes the exit code word, then reads hsave_base+0..7 back into registers 0..7. guest_mode falls when the exit starts.
- R7: Events whose intercept bit is 0 cause no exit and no memory traffic.
- R8: busy is high from the first memory request until the final register load of a sequence. Every command that arrives while busy is ignored, and so is an entry command while in guest mode.
- R9: When not busy, cmd_op = 2 sets gif and cmd_op = 3 clears it, whether or not the block is in guest mode.
- R10: Each beat is one request held with a stable address, direction and data until the cycle in which mem_ack is high. mem_we = 1 marks a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 enter guest, 2 set interrupt flag, 3 clear interrupt flag |
| cmd_blk_base | input | ADDR_W | Control block word address given with the entry command |
| hsave_base | input | ADDR_W | Host save area word address (configuration) |
| evt_vec | input | EVT_W | Guest event lines, one per intercept bit |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Beat complete; read data valid |
| mem_rdata | input | DATA_W | Read data |
| rf_sel | output | IDX_W | Register index being saved or loaded |
| rf_rdata | input | DATA_W | Value of the selected register |
| rf_wen | output | 1 | Load strobe for the selected register |
| rf_wdata | output | DATA_W | Value to load |
| busy | output | 1 | A switch sequence is in progress |
| guest_mode | output | 1 | Guest is running |
| nested_en | output | 1 | Nested translation enabled |
| gif | output | 1 | Global interrupt flag |
| exit_code | output | CODE_W | Index of the intercept that caused the last exit |

## Verification
The assertions assume that mem_ack is high only while mem_req is high and never two cycles in a row. The bench memory follows this rule by acknowledging each request exactly one cycle after it first appears. They also assume the register file answers rf_sel in the same cycle. The bench models it as a plain array read combinationally and written on the strobe. Commands and events are driven as single-cycle pulses between clock edges. Some of these pulses land deliberately while a sequence is running or while the intercept is clear, so that the ignore rules are exercised without breaking the handshake.

// File: rtl/wsw_pkg.sv
package wsw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HSAVE,
        ST_ICPT,
        ST_CTRL,
        ST_GLOAD,
        ST_GUEST,
        ST_GSAVE,
        ST_CODE,
        ST_HLOAD
    } phase_e;

    localparam logic [1:0] OP_ENTER   = 2'd1;
    localparam logic [1:0] OP_GIF_SET = 2'd2;
    localparam logic [1:0] OP_GIF_CLR = 2'd3;

    localparam int OFF_ICPT  = 0;
    localparam int OFF_CTRL  = 1;
    localparam int OFF_CODE  = 2;
    localparam int OFF_STATE = 3;

endpackage

// File: rtl/wsw_prio.sv
module wsw_prio #(
    parameter int W      = 64,
    parameter int CODE_W = $clog2(W)
) (
    input  logic [W-1:0]      hit,
    output logic              found,
    output logic [CODE_W-1:0] idx
);
    always_comb begin
        found = |hit;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx = CODE_W'(i);
            end
        end
    end
endmodule

// File: rtl/wsw_agen.sv
module wsw_agen
    import wsw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] hsave_base,
    input  logic [ADDR_W-1:0] blk_base,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic              is_load
);
    logic [ADDR_W-1:0] idx_ext;

    assign idx_ext = ADDR_W'(idx);

    always_comb begin
        addr    = '0;
        we      = 1'b0;
        is_load = 1'b0;
        case (phase)
            ST_HSAVE: begin
                addr = hsave_base + idx_ext;
                we   = 1'b1;
            end
            ST_ICPT:  addr = blk_base + ADDR_W'(OFF_ICPT);
            ST_CTRL:  addr = blk_base + ADDR_W'(OFF_CTRL);
            ST_GLOAD: begin
                addr    = blk_base + ADDR_W'(OFF_STATE) + idx_ext;
                is_load = 1'b1;
            end
            ST_GSAVE: begin
                addr = blk_base + ADDR_W'(OFF_STATE) + idx_ext;
                we   = 1'b1;
            end
            ST_CODE: begin
                addr = blk_base + ADDR_W'(OFF_CODE);
                we   = 1'b1;
            end
            ST_HLOAD: begin
                addr    = hsave_base + idx_ext;
                is_load = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wsw_fsm.sv
module wsw_fsm
    import wsw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int EVT_W  = 64,
    parameter int NREG   = 8,
    parameter int IDX_W  = $clog2(NREG),
    parameter int CODE_W = $clog2(EVT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_blk_base,
    input  logic [ADDR_W-1:0] hsave_base,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              hit_any,
    input  logic [CODE_W-1:0] hit_idx,
    output phase_e            phase,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] blk_q,
    output logic [ADDR_W-1:0] hsave_q,
    output logic [EVT_W-1:0]  icpt,
    output logic              busy,
    output logic              guest_mode,
    output logic              nested_en,
    output logic              gif,
    output logic [CODE_W-1:0] exit_code
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [ADDR_W-1:0]   blk;
        logic [ADDR_W-1:0]   hsave;
        logic [EVT_W-1:0]    icpt;
        logic                np;
        logic                guest;
        logic                nested;
        logic                gif;
        logic [CODE_W-1:0]   code;
    } st_t;

    st_t st_d, st_q;
    logic busy_w;
    logic last_w;

    assign busy_w = (st_q.phase != ST_IDLE) && (st_q.phase != ST_GUEST);
    assign last_w = (st_q.idx == LAST_IDX);

    always_comb begin
        st_d = st_q;

        if (cmd_valid && !busy_w) begin
            case (cmd_op)
                OP_GIF_SET: st_d.gif = 1'b1;
                OP_GIF_CLR: st_d.gif = 1'b0;
                OP_ENTER: begin
                    if (st_q.phase == ST_IDLE) begin
                        st_d.phase = ST_HSAVE;
                        st_d.idx   = '0;
                        st_d.blk   = cmd_blk_base;
                        st_d.hsave = hsave_base;
                    end
                end
                default: ;
            endcase
        end

        case (st_q.phase)
            ST_HSAVE: begin
                if (mem_ack) begin
                    if (last_w) begin
                        st_d.phase = ST_ICPT;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            ST_ICPT: begin
                if (mem_ack) begin
                    st_d.icpt  = mem_rdata[EVT_W-1:0];
                    st_d.phase = ST_CTRL;
                end
            end
            ST_CTRL: begin
                if (mem_ack) begin
                    st_d.np    = mem_rdata[0];
                    st_d.phase = ST_GLOAD;
                    st_d.idx   = '0;
                end
            end
            ST_GLOAD: begin
                if (mem_ack) begin
                    if (last_w) begin
                        st_d.phase  = ST_GUEST;
                        st_d.idx    = '0;
                        st_d.guest  = 1'b1;
                        st_d.nested = st_q.np;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            ST_GUEST: begin
                if (hit_any) begin
                    st_d.phase  = ST_GSAVE;
                    st_d.idx    = '0;
                    st_d.code   = hit_idx;
                    st_d.guest  = 1'b0;
                    st_d.nested = 1'b0;
                end
            end
            ST_GSAVE: begin
                if (mem_ack) begin
                    if (last_w) begin
                        st_d.phase = ST_CODE;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            ST_CODE: begin
                if (mem_ack) begin
                    st_d.phase = ST_HLOAD;
                    st_d.idx   = '0;
                end
            end
            ST_HLOAD: begin
                if (mem_ack) begin
                    if (last_w) begin
                        st_d.phase = ST_IDLE;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase      = st_q.phase;
    assign idx        = st_q.idx;
    assign blk_q      = st_q.blk;
    assign hsave_q    = st_q.hsave;
    assign icpt       = st_q.icpt;
    assign busy       = busy_w;
    assign guest_mode = st_q.guest;
    assign nested_en  = st_q.nested;
    assign gif        = st_q.gif;
    assign exit_code  = st_q.code;
endmodule

// File: rtl/wsw_seq.sv
module wsw_seq
    import wsw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int EVT_W  = 64,
    parameter int NREG   = 8,
    localparam int IDX_W  = $clog2(NREG),
    localparam int CODE_W = $clog2(EVT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_blk_base,
    input  logic [ADDR_W-1:0] hsave_base,
    input  logic [EVT_W-1:0]  evt_vec,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  rf_sel,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_wen,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              busy,
    output logic              guest_mode,
    output logic              nested_en,
    output logic              gif,
    output logic [CODE_W-1:0] exit_code
);
    phase_e            phase;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] blk_q;
    logic [ADDR_W-1:0] hsave_q;
    logic [EVT_W-1:0]  icpt;
    logic [EVT_W-1:0]  hit;
    logic              hit_any;
    logic [CODE_W-1:0] hit_idx;
    logic              is_load;

    for (genvar g = 0; g < EVT_W; g++) begin : g_mask
        assign hit[g] = evt_vec[g] & icpt[g];
    end

    wsw_prio #(.W(EVT_W), .CODE_W(CODE_W)) u_prio (
        .hit   (hit),
        .found (hit_any),
        .idx   (hit_idx)
    );

    wsw_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EVT_W  (EVT_W),
        .NREG   (NREG),
        .IDX_W  (IDX_W),
        .CODE_W (CODE_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_blk_base (cmd_blk_base),
        .hsave_base   (hsave_base),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .hit_any      (hit_any),
        .hit_idx      (hit_idx),
        .phase        (phase),
        .idx          (idx),
        .blk_q        (blk_q),
        .hsave_q      (hsave_q),
        .icpt         (icpt),
        .busy         (busy),
        .guest_mode   (guest_mode),
        .nested_en    (nested_en),
        .gif          (gif),
        .exit_code    (exit_code)
    );

    wsw_agen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
        .phase      (phase),
        .idx        (idx),
        .hsave_base (hsave_q),
        .blk_base   (blk_q),
        .addr       (mem_addr),
        .we         (mem_we),
        .is_load    (is_load)
    );

    assign mem_req   = busy;
    assign mem_wdata = (phase == ST_CODE) ? DATA_W'(exit_code) : rf_rdata;
    assign rf_sel    = idx;
    assign rf_wen    = mem_req & mem_ack & is_load;
    assign rf_wdata  = mem_rdata;
endmodule

// File: rtl/wsw_seq_chk.sv
module wsw_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_wen,
    input logic              busy,
    input logic              guest_mode,
    input logic              nested_en,
    input logic              gif
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R4
    nested_guest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nested_en |-> guest_mode);

    // R8
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !guest_mode);

    // R6
    rf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wen |-> mem_req && mem_ack && !mem_we);

    // R3
    enter_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(guest_mode) |-> $past(busy) && $past(mem_ack));

    // R5
    exit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(guest_mode) |-> busy && !nested_en);

    // R9
    gif_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'd2 && !busy |=> gif);
endmodule

bind wsw_seq wsw_seq_chk #(.ADDR_W(ADDR_W)) chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .rf_wen     (rf_wen),
    .busy       (busy),
    .guest_mode (guest_mode),
    .nested_en  (nested_en),
    .gif        (gif)
);

// File: tb/wsw_seq_test.sv
module wsw_seq_test;
    localparam logic [15:0] HS = 16'h0040;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [63:0] data;
    } beat_t;

    typedef struct packed {
        logic [2:0]  idx;
        logic [63:0] data;
    } rfw_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_blk_base = '0;
    logic [15:0] hsave_base = HS;
    logic [63:0] evt_vec = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic [2:0]  rf_sel;
    logic [63:0] rf_rdata;
    logic        rf_wen;
    logic [63:0] rf_wdata;
    logic        busy, guest_mode, nested_en, gif;
    logic [5:0]  exit_code;

    logic [63:0] mem [0:255];
    logic [63:0] rf  [0:7];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = '0;
    logic [63:0] poke_data = '0;

    beat_t exp_mem[$];
    string exp_mtag[$];
    rfw_t  exp_rf[$];
    string exp_rtag[$];
    beat_t mb;
    rfw_t  rb;
    string tg;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    wsw_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_blk_base(cmd_blk_base), .hsave_base(hsave_base), .evt_vec(evt_vec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rf_sel(rf_sel), .rf_rdata(rf_rdata),
        .rf_wen(rf_wen), .rf_wdata(rf_wdata), .busy(busy), .guest_mode(guest_mode),
        .nested_en(nested_en), .gif(gif), .exit_code(exit_code)
    );

    function automatic logic [63:0] host_val(int i);
        return 64'hC0DE_0000_0000_0000 + 64'(i) * 64'h1111;
    endfunction

    assign rf_rdata = rf[rf_sel];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 8; i++) rf[i] <= host_val(i);
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            end
            if (rf_wen) rf[rf_sel] <= rf_wdata;
        end
        if (poke_en) mem[poke_addr] <= poke_data;
    end

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_mem(logic [7:0] a, logic [63:0] d);
        @(negedge clk);
        poke_addr = a;
        poke_data = d;
        poke_en   = 1'b1;
        @(negedge clk);
        poke_en   = 1'b0;
    endtask

    // monitor: pops the scoreboard as beats and loads complete
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ack) begin
                if (exp_mem.size() == 0) begin
                    check(1'b0, "R8 unexpected beat", 64'(mem_addr), 64'hFFFF);
                end else begin
                    mb = exp_mem.pop_front();
                    tg = exp_mtag.pop_front();
                    check(mem_we == mb.we && mem_addr == mb.addr && (!mb.we || mem_wdata == mb.data),
                          tg, mem_we ? mem_wdata : 64'(mem_addr), mb.we ? mb.data : 64'(mb.addr));
                end
            end
            if (rf_wen) begin
                if (exp_rf.size() == 0) begin
                    check(1'b0, "R8 unexpected load", 64'(rf_sel), 64'hFF);
                end else begin
                    rb = exp_rf.pop_front();
                    tg = exp_rtag.pop_front();
                    check(rf_sel == rb.idx && rf_wdata == rb.data, tg, rf_wdata, rb.data);
                end
            end
        end
    end

    task automatic push_beat(logic we, logic [15:0] a, logic [63:0] d, string t);
        exp_mem.push_back('{we: we, addr: a, data: d});
        exp_mtag.push_back(t);
    endtask

    task automatic push_rf(int i, logic [63:0] d, string t);
        exp_rf.push_back('{idx: 3'(i), data: d});
        exp_rtag.push_back(t);
    endtask

    task automatic pulse_cmd(logic [1:0] op, logic [15:0] blk);
        @(negedge clk);
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_blk_base = blk;
        @(negedge clk);
        cmd_valid    = 1'b0;
    endtask

    task automatic wait_idle(string t);
        int n = 0;
        while (busy && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(!busy, t, 64'(busy), 64'd0);
    endtask

    task automatic do_enter(logic [15:0] blk, logic np, bit poke);
        for (int i = 0; i < 8; i++) push_beat(1'b1, HS + 16'(i), rf[i], "R2 host save");
        push_beat(1'b0, blk, '0, "R3 intercept read");
        push_beat(1'b0, blk + 16'd1, '0, "R3 control read");
        for (int i = 0; i < 8; i++) begin
            push_beat(1'b0, blk + 16'd3 + 16'(i), '0, "R3 guest read");
            push_rf(i, mem[blk[7:0] + 8'd3 + 8'(i)], "R3 guest load");
        end
        pulse_cmd(2'd1, blk);
        check(busy && mem_req, "R8 busy at first request", 64'(busy), 64'd1);
        if (poke) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'd1; cmd_blk_base = 16'h00C0;
            @(negedge clk);
            cmd_op = 2'd2;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        wait_idle("R8 entry completes");
        check(guest_mode, "R3 guest mode set", 64'(guest_mode), 64'd1);
        check(nested_en == np, "R4 nested enable from control word", 64'(nested_en), 64'(np));
        check(exp_mem.size() == 0 && exp_rf.size() == 0, "R2 entry beats all seen",
              64'(exp_mem.size()), 64'd0);
    endtask

    task automatic do_exit(logic [15:0] blk, logic [63:0] ev, logic [5:0] code);
        for (int i = 0; i < 8; i++) push_beat(1'b1, blk + 16'd3 + 16'(i), rf[i], "R6 guest save");
        push_beat(1'b1, blk + 16'd2, 64'(code), "R5 exit code word");
        for (int i = 0; i < 8; i++) begin
            push_beat(1'b0, HS + 16'(i), '0, "R6 host read");
            push_rf(i, mem[HS[7:0] + 8'(i)], "R6 host load");
        end
        @(negedge clk);
        evt_vec = ev;
        @(negedge clk);
        evt_vec = '0;
        check(busy && !guest_mode, "R5 exit started", 64'(busy), 64'd1);
        check(!nested_en, "R4 nested cleared on exit", 64'(nested_en), 64'd0);
        wait_idle("R8 exit completes");
        check(!guest_mode, "R6 guest mode clear", 64'(guest_mode), 64'd0);
        check(exit_code == code, "R5 exit code", 64'(exit_code), 64'(code));
        check(exp_mem.size() == 0 && exp_rf.size() == 0, "R6 exit beats all seen",
              64'(exp_mem.size()), 64'd0);
        for (int i = 0; i < 8; i++)
            check(rf[i] == host_val(i), "R6 host restored", rf[i], host_val(i));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !guest_mode && !nested_en && !gif && !mem_req && exit_code == 0,
              "R1 reset state", {busy, guest_mode, nested_en, gif, mem_req}, 64'd0);

        // guest A: intercepts 5, 9, 40; nested on
        set_mem(8'h80, (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 40));
        set_mem(8'h81, 64'd1);
        for (int i = 0; i < 8; i++) set_mem(8'h83 + 8'(i), 64'hA000_0000_0000_0000 + 64'(i));
        // guest B: intercept 63 only; nested off
        set_mem(8'hC0, 64'd1 << 63);
        set_mem(8'hC1, 64'd0);
        for (int i = 0; i < 8; i++) set_mem(8'hC3 + 8'(i), 64'hB000_0000_0000_0000 + 64'(i));

        // R9 interrupt flag
        pulse_cmd(2'd2, '0);
        check(gif, "R9 set flag", 64'(gif), 64'd1);
        pulse_cmd(2'd3, '0);
        check(!gif, "R9 clear flag", 64'(gif), 64'd0);

        // entry with commands poked while busy (R8)
        do_enter(16'h0080, 1'b1, 1'b1);
        check(!gif, "R8 flag command ignored while busy", 64'(gif), 64'd0);

        // R8 entry while in guest ignored
        pulse_cmd(2'd1, 16'h00C0);
        repeat (20) @(negedge clk);
        check(guest_mode && !busy, "R8 entry ignored in guest", 64'(busy), 64'd0);

        // R9 flag works in guest
        pulse_cmd(2'd2, '0);
        check(gif, "R9 set flag in guest", 64'(gif), 64'd1);

        // R7 un-intercepted event
        @(negedge clk);
        evt_vec = (64'd1 << 3) | (64'd1 << 63);
        repeat (10) @(negedge clk);
        evt_vec = '0;
        check(guest_mode && !busy && !mem_req, "R7 event ignored", 64'(guest_mode), 64'd1);

        // R5 several hits: lowest (9) wins; bit 2 not intercepted
        do_exit(16'h0080, (64'd1 << 2) | (64'd1 << 9) | (64'd1 << 40), 6'd9);
        check(mem[8'h82] == 64'd9, "R5 code stored in block", mem[8'h82], 64'd9);

        // guest B, top intercept index
        do_enter(16'h00C0, 1'b0, 1'b0);
        do_exit(16'h00C0, {64{1'b1}}, 6'd63);

        // guest A again with intercepts 0 and 63, all events
        set_mem(8'h80, (64'd1 << 0) | (64'd1 << 63));
        do_enter(16'h0080, 1'b1, 1'b0);
        do_exit(16'h0080, {64{1'b1}}, 6'd0);
        check(gif, "R9 flag kept across switches", 64'(gif), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule